// File: doc/BRIEF.md
# Dual Cascadable Interval Timer

This block holds two counter/timers that each produce an interrupt pulse after a programmed number of periods of a slow counter clock. Each counter either climbs from zero to a target or descends from a load value to zero. It then signals, reloads and repeats, so it acts as a periodic tick source. A join control merges the pair into a single counter of twice the width. In that mode the second register supplies the upper byte, and only the first counter's interrupt is used.

The counter clock is an ordinary input that is sampled in the system clock domain. Its rising and falling transitions become single-cycle strobes, so the whole block runs on one system clock. Software programs the block through a plain write port with no handshake. There are two value registers and one control register. A write to a value register also restarts the counter it feeds from its starting value.

Top module: `dual_interval_timer`

## Requirements
- R1: Up mode (control bit 0 = 1 for the low counter, bit 1 = 1 for the high counter). After a value write, the counter starts at zero and gains one on each counter-clock rise. On the falling counter-clock edge that follows the rise on which it reaches the target, its interrupt fires. With target T, the first interrupt comes on the T-th counter-clock period after the write.
- R2: Down mode (control bit = 0). After a value write, the counter starts at the written value L and loses one on each rise. The interrupt fires on the falling edge after it reaches zero, so the first interrupt comes on the L-th period.
- R3: Each interrupt is a one-system-clock pulse. It follows a counter-clock falling edge and appears while the counter clock is still low.
- R4: On the rise after an interrupt, the counter reloads: to zero in up mode, or to L in down mode. Interrupts therefore repeat every T+1 (or L+1) periods.
- R5: Writing the value register at address 0 (low counter) or address 1 (high counter) while a counter runs restarts that counter from its starting value.
- R6: Control bit 2 joins the two counters. The low counter then counts 16 bits with the value {address 1, address 0}, in the direction set by bit 0. Bit 1 is ignored, and a write to either address restarts the joined counter.
- R7: While the counters are joined, irq_b stays low.
- R8: Run bits are control bit 3 (low counter) and bit 4 (high counter). A counter whose run bit is 0 neither counts nor interrupts.
- R9: A counter can be stopped while it holds its terminal value and then restarted with no value write in between. It then holds that value and issues one extra interrupt on the next falling edge, then reloads on the following rise.
- R10: A synchronous active-low reset clears the registers, counters and interrupts. After reset, setting only the run bit of the low counter gives one interrupt per period, because a down count from zero is already at its terminal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_clk | input | 1 | Counter clock, sampled on clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 low value, 1 high value, 2 control |
| wr_data | input | W (8) | Write data |
| irq_a | output | 1 | Low counter interrupt pulse |
| irq_b | output | 1 | High counter interrupt pulse |

## Verification
The bench builds the block with its defaults: 8-bit counters and a two-stage sampler, so the joined counter is 16 bits. Joined cases use a high byte of one, which puts targets of a few hundred periods within reach. The counter-clock half period of eight system clocks leaves the sampler latency inside the low phase, so the timing of the interrupt against the falling edge can be observed. Directed cases cover both directions, rewrites during a count, the join with a contradicting high direction bit, and stop and restart at the terminal value. Seeded random programs are compared against a period-level model.

// File: rtl/ict_pkg.sv
package ict_pkg;
  localparam logic [1:0] ADDR_VAL_LO = 2'd0;
  localparam logic [1:0] ADDR_VAL_HI = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  localparam int CTRL_BITS = 5;

  typedef struct packed {
    logic run_b;
    logic run_a;
    logic join_ab;
    logic up_b;
    logic up_a;
  } ctrl_t;
endpackage

// File: rtl/ict_edge.sv
module ict_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [SYNC:0] stage;

  genvar g;
  generate
    for (g = 0; g <= SYNC; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage[g] <= 1'b0;
        else if (g == 0) stage[g] <= din;
        else stage[g] <= stage[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign rise = stage[SYNC-1] & ~stage[SYNC];
  assign fall = ~stage[SYNC-1] & stage[SYNC];
endmodule

// File: rtl/ict_unit.sv
module ict_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise,
  input  logic         fall,
  input  logic         run,
  input  logic         up,
  input  logic         ld,
  input  logic [W-1:0] val,
  output logic         irq
);
  logic [W-1:0] cnt;
  logic [W-1:0] term;
  logic [W-1:0] start;
  logic         fired;
  logic         run_q;
  logic         at_term;

  assign term    = up ? val : '0;
  assign start   = up ? '0 : val;
  assign at_term = (cnt == term);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      fired <= 1'b0;
      run_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      run_q <= run;
      irq   <= 1'b0;
      if (ld) begin
        cnt   <= start;
        fired <= 1'b0;
      end else if (run) begin
        if (!run_q && at_term) begin
          fired <= 1'b0;
        end else if (rise) begin
          if (at_term) begin
            if (fired) begin
              cnt   <= start;
              fired <= 1'b0;
            end
          end else begin
            cnt <= up ? cnt + 1'b1 : cnt - 1'b1;
          end
        end else if (fall && at_term && !fired) begin
          irq   <= 1'b1;
          fired <= 1'b1;
        end
      end
    end
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(cnt));

  // R3
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R3
  irq_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(fall));

  // R9
  restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !run_q && at_term && !ld) |=> $stable(cnt));
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_clk,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         irq_a,
  output logic         irq_b
);
  import ict_pkg::*;

  localparam int WJ = 2 * W;

  logic [W-1:0]  val_lo;
  logic [W-1:0]  val_hi;
  ctrl_t         ctrl;
  logic          ld_lo_q;
  logic          ld_hi_q;
  logic          rise;
  logic          fall;
  logic [WJ-1:0] val_a;
  logic          run_b_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_lo  <= '0;
      val_hi  <= '0;
      ctrl    <= '0;
      ld_lo_q <= 1'b0;
      ld_hi_q <= 1'b0;
    end else begin
      ld_lo_q <= wr_en && ((wr_addr == ADDR_VAL_LO) ||
                           ((wr_addr == ADDR_VAL_HI) && ctrl.join_ab));
      ld_hi_q <= wr_en && (wr_addr == ADDR_VAL_HI) && !ctrl.join_ab;
      if (wr_en) begin
        case (wr_addr)
          ADDR_VAL_LO: val_lo <= wr_data;
          ADDR_VAL_HI: val_hi <= wr_data;
          ADDR_CTRL:   ctrl   <= ctrl_t'(wr_data[CTRL_BITS-1:0]);
          default: ;
        endcase
      end
    end
  end

  assign val_a     = ctrl.join_ab ? {val_hi, val_lo} : {{W{1'b0}}, val_lo};
  assign run_b_eff = ctrl.run_b & ~ctrl.join_ab;

  ict_edge #(.SYNC(SYNC)) edge_i (
    .clk(clk), .rst_n(rst_n), .din(cnt_clk), .rise(rise), .fall(fall)
  );

  ict_unit #(.W(WJ)) unit_a_i (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .run(ctrl.run_a), .up(ctrl.up_a), .ld(ld_lo_q), .val(val_a), .irq(irq_a)
  );

  ict_unit #(.W(W)) unit_b_i (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
    .run(run_b_eff), .up(ctrl.up_b), .ld(ld_hi_q), .val(val_hi), .irq(irq_b)
  );

  // R7
  joined_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.join_ab && $past(ctrl.join_ab)) |-> !irq_b);
endmodule

// File: tb/dual_interval_timer_tb_top.sv
module dual_interval_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HP         = 8;
  localparam int W          = 8;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_clk = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic irq_a, irq_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_interval_timer #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_clk(cnt_clk), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq_a(irq_a), .irq_b(irq_b)
  );

  int total = 0, bad = 0;
  int act_a = 0, act_b = 0, exp_a = 0, exp_b = 0;
  int hi_bad = 0, wide_bad = 0, cycles = 0;
  logic prev_a = 1'b0, prev_b = 1'b0;

  int ra = 0, rb = 0, ca = 0, cb = 0;
  bit upa = 0, upb = 0, jn = 0, rna = 0, rnb = 0, fa = 0, fb = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n) begin
      if (irq_a) act_a <= act_a + 1;
      if (irq_b) act_b <= act_b + 1;
      if ((irq_a || irq_b) && cnt_clk) hi_bad <= hi_bad + 1;
      if ((irq_a && prev_a) || (irq_b && prev_b)) wide_bad <= wide_bad + 1;
      prev_a <= irq_a;
      prev_b <= irq_b;
    end
    if (cycles == WATCHDOG) begin
      $display("FAIL watchdog expired act=%0d exp=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int val_a_f();
    return jn ? rb * 256 + ra : ra;
  endfunction

  task automatic m_rise(input bit run, input bit up, input int v,
                        inout int c, inout bit f);
    int t;
    t = up ? v : 0;
    if (!run) return;
    if (c == t) begin
      if (f) begin c = up ? 0 : v; f = 0; end
    end else c = up ? c + 1 : c - 1;
  endtask

  task automatic m_fall(input bit run, input bit up, input int v,
                        inout int c, inout bit f, inout int e);
    int t;
    t = up ? v : 0;
    if (run && c == t && !f) begin e++; f = 1; end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cnt_clk = 1'b1;
      m_rise(rna, upa, val_a_f(), ca, fa);
      m_rise(rnb && !jn, upb, rb, cb, fb);
      repeat (HP) @(negedge clk);
      cnt_clk = 1'b0;
      m_fall(rna, upa, val_a_f(), ca, fa, exp_a);
      m_fall(rnb && !jn, upb, rb, cb, fb, exp_b);
      repeat (HP) @(negedge clk);
    end
  endtask

  task automatic wr(input int addr, input int data);
    bit old_a, old_b;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr[1:0]; wr_data = data[W-1:0];
    @(negedge clk);
    wr_en = 1'b0;
    case (addr)
      0: begin ra = data; ca = upa ? 0 : val_a_f(); fa = 0; end
      1: begin
        rb = data;
        if (jn) begin ca = upa ? 0 : val_a_f(); fa = 0; end
        else begin cb = upb ? 0 : rb; fb = 0; end
      end
      default: begin
        old_a = rna; old_b = rnb && !jn;
        upa = data[0]; upb = data[1]; jn = data[2]; rna = data[3]; rnb = data[4];
        if (rna && !old_a && ca == (upa ? val_a_f() : 0)) fa = 0;
        if (rnb && !jn && !old_b && cb == (upb ? rb : 0)) fb = 0;
      end
    endcase
    repeat (2) @(negedge clk);
  endtask

  int base_a, base_b;

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_a, 0, "R10 irq_a after reset");
    chk(irq_b, 0, "R10 irq_b after reset");
    tick(3);
    chk(act_a + act_b, 0, "R8 R10 idle after reset");

    // R10: registers zero, down from zero, run only
    base_a = act_a;
    wr(2, 8'h08);
    tick(3);
    chk(act_a - base_a, 3, "R10 zero load every period");
    wr(2, 8'h00);

    // R1 up count, R4 reload period
    wr(2, 8'h01); wr(0, 3); wr(2, 8'h09);
    base_a = act_a;
    tick(2); chk(act_a - base_a, 0, "R1 before target");
    tick(1); chk(act_a - base_a, 1, "R1 at target");
    tick(3); chk(act_a - base_a, 1, "R4 reload gap");
    tick(1); chk(act_a - base_a, 2, "R4 period T+1");

    // R2 down count, high counter independent
    wr(2, 8'h00); wr(0, 2); wr(1, 4); wr(2, 8'h18);
    base_a = act_a; base_b = act_b;
    tick(2); chk(act_a - base_a, 1, "R2 down reach zero");
    tick(3); chk(act_a - base_a, 2, "R2 period L+1");
    chk(act_b - base_b, 1, "R2 high counter down");

    // R5 rewrite restarts
    wr(2, 8'h01); wr(0, 5); wr(2, 8'h09);
    base_a = act_a;
    tick(3); wr(0, 5);
    tick(4); chk(act_a - base_a, 0, "R5 rewrite restarted count");
    tick(1); chk(act_a - base_a, 1, "R5 fires after full span");

    // R9 restart at terminal, R8 stopped
    wr(2, 8'h01); wr(0, 2); wr(2, 8'h09);
    base_a = act_a;
    tick(2); chk(act_a - base_a, 1, "R9 first terminal irq");
    wr(2, 8'h01);
    tick(3); chk(act_a - base_a, 1, "R8 stopped no irq");
    wr(2, 8'h09);
    tick(1); chk(act_a - base_a, 2, "R9 extra irq on restart");
    tick(3); chk(act_a - base_a, 3, "R9 reload after extra");
    wr(2, 8'h01); wr(0, 3); wr(2, 8'h09);
    base_a = act_a;
    tick(1); wr(2, 8'h01); tick(2); wr(2, 8'h09);
    tick(2); chk(act_a - base_a, 1, "R9 no extra when not at terminal");

    // R6 joined up, high dir bit contradicts; R7 irq_b low
    wr(2, 8'h05); wr(0, 4); wr(1, 1); wr(2, 8'h1D);
    base_a = act_a; base_b = act_b;
    tick(259); chk(act_a - base_a, 0, "R6 joined up before 260");
    tick(1); chk(act_a - base_a, 1, "R6 joined up at 260");
    chk(act_b - base_b, 0, "R7 irq_b quiet joined");
    wr(2, 8'h06); wr(0, 2); wr(1, 1); wr(2, 8'h0E);
    base_a = act_a;
    tick(257); chk(act_a - base_a, 0, "R6 joined down before 258");
    tick(1); chk(act_a - base_a, 1, "R6 joined down at 258");
    wr(2, 8'h00);

    // random programs against the model
    exp_a = act_a; exp_b = act_b;
    for (int it = 0; it < 24; it++) begin
      int c, va, vb, n;
      c = $urandom_range(0, 7);
      va = $urandom_range(0, 9);
      vb = c[2] ? $urandom_range(0, 1) : $urandom_range(0, 9);
      n = $urandom_range(5, 40);
      wr(2, c); wr(0, va); wr(1, vb);
      wr(2, c | 8'h08 | ($urandom_range(0, 1) << 4));
      tick(n);
      chk(act_a, exp_a, "R1 R2 R6 random irq_a");
      chk(act_b, exp_b, "R2 R7 random irq_b");
      wr(2, c);
    end

    chk(hi_bad, 0, "R3 irq while counter clock high");
    chk(wide_bad, 0, "R3 irq wider than one cycle");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule